// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides whether a memory access may proceed once the translation hardware has located the matching page-table entry. It gets the second word of that entry, the protection-key bits and no-execute bit of the segment descriptor, the current privilege state, two 64-bit key-mask registers (one for data accesses, one for instruction fetches), a switch that turns per-page key masking on or off, and the kind of access: load, store or fetch.

Three separate permission sources are computed and ANDed into one read/write/execute mask. The first is the no-execute/guarded sources. The second is a 3-bit protection code decoded under a privilege-dependent key. The third is the 2-bit-per-key access masks. The mask is compared against the right that the access needs, which gives a grant or deny result. On a deny, one cause bit is reported for each source that blocked the access. Results are registered: a strobe on `in_valid` produces the result on the next cycle, qualified by `out_valid`. A two-state machine sequences the result. State IDLE takes the transition "strobe" to REPORT. REPORT takes "strobe again" back to REPORT, or "no strobe" to IDLE. `out_valid` is high exactly in REPORT.

Top module: `pgperm_eval`

## Requirements
- R1: The protection key is `seg_kp` when `prob_state` is 1 and `seg_ks` when it is 0.
- R2: The 3-bit protection code is {pte_word[63], pte_word[1:0]}: entry bit 63 becomes code bit 2, and entry bits 1:0 become code bits 1:0.
- R3: With key 0, codes 0, 1 and 2 allow read, write and execute; codes 3 and 6 allow read and execute; codes 4, 5 and 7 allow nothing.
- R4: With key 1, code 2 allows read, write and execute; codes 1 and 3 allow read and execute; codes 0, 4, 5, 6 and 7 allow nothing.
- R5: If entry bit 2 (no-execute), entry bit 3 (guarded) or `seg_nx` is set, execute is removed and read and write are left untouched.
- R6: The page key is k = {pte_word[61:60], pte_word[11:9]}, and it selects the 2-bit field amr[2*(31-k)+1 : 2*(31-k)]. When `key_en` is 1, field bit 1 removes write and field bit 0 removes read. When `key_en` is 0, the key masks remove nothing.
- R7: When `key_en` is 1, iamr bit 2*(31-k) removes execute.
- R8: `out_perm` (bit 2 execute, bit 1 write, bit 0 read) is the AND of the three sources. The access codes are 0 load (needs read), 1 store (needs write), 2 fetch (needs execute) and 3, which is treated as a load. `out_grant` is 1 exactly when the needed right is present in `out_perm`.
- R9: On a denied fetch, cause bit 0 (no-execute/guard) is set if that source removed execute. Otherwise cause bit 1 (protection code) is set if the code removed execute. Cause bit 2 (key mask) is set if the IAMR removed execute, whatever the other two bits are.
- R10: On a denied load or store, cause bit 1 is set if the protection code lacks the needed right, cause bit 2 is set if the key mask lacks it, and cause bit 3 (store) is set for a store.
- R11: The result of a strobe appears on the outputs in the next cycle with `out_valid` = 1. `out_valid` is 0 in the cycle after a cycle with no strobe, and the output fields then keep their last values.
- R12: A granted access reports `out_cause` = 0. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Evaluation strobe |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| pte_word | input | 64 | Second word of the matched page-table entry |
| seg_ks | input | 1 | Segment key used in privileged state |
| seg_kp | input | 1 | Segment key used in problem state |
| seg_nx | input | 1 | Segment no-execute |
| prob_state | input | 1 | 1 = problem (user) state |
| amr | input | 64 | Data access key mask, 2 bits per key |
| iamr | input | 64 | Instruction access key mask, 2 bits per key |
| key_en | input | 1 | Enables key-mask protection |
| out_valid | output | 1 | Result valid |
| out_perm | output | 3 | Allowed rights {execute, write, read} |
| out_grant | output | 1 | Access allowed |
| out_cause | output | 4 | {store, key mask, protection code, no-exec/guard} |

## Verification
The assertions assume that `in_valid` is low while reset is held. They also assume that the access code and entry fields are stable around the sampling edge, because the store-cause check looks one cycle back at `acc_type`. The bench changes inputs only on the falling clock edge and keeps `in_valid` at 0 throughout reset. Every strobe carries a fully defined operand set, so the AND of the three sources, and the cause bits derived from it, never see unknown values.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
    localparam int PTE_W      = 64;
    localparam int KEY_W      = 5;
    localparam int NUM_KEYS   = 1 << KEY_W;
    localparam int MASK_W     = 2 * NUM_KEYS;
    localparam int SH_W       = KEY_W + 1;
    localparam int PP0_BIT    = 63;
    localparam int NOEXEC_BIT = 2;
    localparam int GUARD_BIT  = 3;
    localparam int KEYHI_MSB  = 61;
    localparam int KEYHI_LSB  = 60;
    localparam int KEYLO_MSB  = 11;
    localparam int KEYLO_LSB  = 9;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic store;
        logic keymask;
        logic pp;
        logic nxg;
    } cause_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;
endpackage

// File: rtl/pgperm_base_dec.sv
module pgperm_base_dec
    import pgperm_pkg::*;
(
    input  logic       pp0,
    input  logic [1:0] pp_lo,
    input  logic       pte_noexec,
    input  logic       pte_guard,
    input  logic       seg_ks,
    input  logic       seg_kp,
    input  logic       seg_nx,
    input  logic       prob_state,
    output perm_t      pp_perm,
    output perm_t      nx_perm
);
    localparam perm_t P_NONE = '{x: 1'b0, w: 1'b0, r: 1'b0};
    localparam perm_t P_RX   = '{x: 1'b1, w: 1'b0, r: 1'b1};
    localparam perm_t P_RWX  = '{x: 1'b1, w: 1'b1, r: 1'b1};

    logic       sel_key;
    logic [2:0] code;

    // R1: privilege picks the key, R2: code assembly
    assign sel_key = prob_state ? seg_kp : seg_ks;
    assign code    = {pp0, pp_lo};

    // R3 / R4: code tables per key
    always_comb begin
        pp_perm = P_NONE;
        if (!sel_key) begin
            unique case (code)
                3'd0, 3'd1, 3'd2: pp_perm = P_RWX;
                3'd3, 3'd6:       pp_perm = P_RX;
                default:          pp_perm = P_NONE;
            endcase
        end else begin
            unique case (code)
                3'd2:       pp_perm = P_RWX;
                3'd1, 3'd3: pp_perm = P_RX;
                default:    pp_perm = P_NONE;
            endcase
        end
    end

    // R5: only execute can be removed here
    always_comb begin
        nx_perm   = P_RWX;
        nx_perm.x = ~(pte_noexec | pte_guard | seg_nx);
    end
endmodule

// File: rtl/pgperm_key_mask.sv
module pgperm_key_mask
    import pgperm_pkg::*;
(
    input  logic [KEY_W-1:0]  page_key,
    input  logic [MASK_W-1:0] amr,
    input  logic [MASK_W-1:0] iamr,
    input  logic              key_en,
    output perm_t             key_perm
);
    logic [SH_W-1:0] shift;
    logic [1:0]      data_fld;
    logic            fetch_bit;

    // field for key k sits at 2*((NUM_KEYS-1)-k); for a full-width key that is ~k
    assign shift     = {~page_key, 1'b0};
    assign data_fld  = amr[shift +: 2];
    assign fetch_bit = iamr[shift];

    // R6 / R7
    always_comb begin
        if (key_en) begin
            key_perm.r = ~data_fld[0];
            key_perm.w = ~data_fld[1];
            key_perm.x = ~fetch_bit;
        end else begin
            key_perm = '{x: 1'b1, w: 1'b1, r: 1'b1};
        end
    end
endmodule

// File: rtl/pgperm_fault_gen.sv
module pgperm_fault_gen
    import pgperm_pkg::*;
(
    input  logic [1:0] acc_type,
    input  perm_t      nx_perm,
    input  perm_t      pp_perm,
    input  perm_t      key_perm,
    output perm_t      perm,
    output logic       grant,
    output cause_t     cause
);
    perm_t need;
    acc_e  acc;

    assign acc = acc_e'(acc_type);

    // R8: needed right per access code
    always_comb begin
        need = '0;
        unique case (acc)
            ACC_STORE: need.w = 1'b1;
            ACC_FETCH: need.x = 1'b1;
            ACC_LOAD,
            ACC_RSVD:  need.r = 1'b1;
            default:   need.r = 1'b1;
        endcase
    end

    assign perm  = nx_perm & pp_perm & key_perm;
    assign grant = |(need & perm);

    // R9 / R10: cause bits on a deny only
    always_comb begin
        cause = '0;
        if (!grant) begin
            if (acc == ACC_FETCH) begin
                cause.nxg     = ~nx_perm.x;
                cause.pp      = nx_perm.x & ~pp_perm.x;
                cause.keymask = ~key_perm.x;
            end else begin
                cause.pp      = |(need & ~pp_perm);
                cause.keymask = |(need & ~key_perm);
                cause.store   = (acc == ACC_STORE);
            end
        end
    end
endmodule

// File: rtl/pgperm_eval.sv
module pgperm_eval
    import pgperm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  acc_type,
    input  logic [63:0] pte_word,
    input  logic        seg_ks,
    input  logic        seg_kp,
    input  logic        seg_nx,
    input  logic        prob_state,
    input  logic [63:0] amr,
    input  logic [63:0] iamr,
    input  logic        key_en,
    output logic        out_valid,
    output logic [2:0]  out_perm,
    output logic        out_grant,
    output logic [3:0]  out_cause
);
    perm_t  pp_perm, nx_perm, key_perm, comb_perm;
    cause_t comb_cause;
    logic   comb_grant;
    state_e state_q, state_d;

    logic [KEY_W-1:0] page_key;
    logic             unused_pte_bits;

    assign page_key = {pte_word[KEYHI_MSB:KEYHI_LSB], pte_word[KEYLO_MSB:KEYLO_LSB]};
    assign unused_pte_bits = ^{pte_word[62], pte_word[59:12], pte_word[8:4]};

    pgperm_base_dec u_base (
        .pp0        (pte_word[PP0_BIT]),
        .pp_lo      (pte_word[1:0]),
        .pte_noexec (pte_word[NOEXEC_BIT]),
        .pte_guard  (pte_word[GUARD_BIT]),
        .seg_ks     (seg_ks),
        .seg_kp     (seg_kp),
        .seg_nx     (seg_nx),
        .prob_state (prob_state),
        .pp_perm    (pp_perm),
        .nx_perm    (nx_perm)
    );

    pgperm_key_mask u_key (
        .page_key (page_key),
        .amr      (amr),
        .iamr     (iamr),
        .key_en   (key_en),
        .key_perm (key_perm)
    );

    pgperm_fault_gen u_fault (
        .acc_type (acc_type),
        .nx_perm  (nx_perm),
        .pp_perm  (pp_perm),
        .key_perm (key_perm),
        .perm     (comb_perm),
        .grant    (comb_grant),
        .cause    (comb_cause)
    );

    // next-state: IDLE --strobe--> REPORT, REPORT --strobe again--> REPORT,
    // REPORT --no strobe--> IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = in_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // R11 / R12: result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_perm  <= '0;
            out_grant <= 1'b0;
            out_cause <= '0;
        end else if (in_valid) begin
            out_perm  <= comb_perm;
            out_grant <= comb_grant;
            out_cause <= comb_cause;
        end
    end

    assign out_valid = (state_q == ST_REPORT);

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r11_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r11_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_perm) && $stable(out_grant) && $stable(out_cause));

    a_r12_grant_clean: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_grant |-> out_cause == 4'b0000);

    a_r9_deny_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_grant |-> out_cause[2:0] != 3'b000);

    a_r10_store_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && acc_type != 2'd1 |=> !out_cause[3]);

    a_r5_nx_blocks_exec: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (pte_word[NOEXEC_BIT] || pte_word[GUARD_BIT] || seg_nx) |=> !out_perm[2]);

    a_r6_key_off_keeps_rw: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !key_en && !out_cause[3] |=> !out_cause[2]);
endmodule

// File: tb/pgperm_eval_tb_top.sv
`timescale 1ns/1ps
module pgperm_eval_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  acc_type;
    logic [63:0] pte_word;
    logic        seg_ks, seg_kp, seg_nx, prob_state;
    logic [63:0] amr, iamr;
    logic        key_en;
    logic        out_valid;
    logic [2:0]  out_perm;
    logic        out_grant;
    logic [3:0]  out_cause;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    pgperm_eval dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_type(acc_type),
        .pte_word(pte_word), .seg_ks(seg_ks), .seg_kp(seg_kp), .seg_nx(seg_nx),
        .prob_state(prob_state), .amr(amr), .iamr(iamr), .key_en(key_en),
        .out_valid(out_valid), .out_perm(out_perm), .out_grant(out_grant),
        .out_cause(out_cause)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_pte(input logic [2:0] code, input logic n,
                                           input logic g, input logic [4:0] key);
        logic [63:0] p;
        p = 64'h0000_5A5A_A5A0_0000;
        p[63]    = code[2];
        p[1:0]   = code[1:0];
        p[2]     = n;
        p[3]     = g;
        p[61:60] = key[4:3];
        p[11:9]  = key[2:0];
        return p;
    endfunction

    function automatic logic [63:0] fld(input logic [4:0] key, input logic [1:0] v);
        return {62'd0, v} << (2 * (31 - int'(key)));
    endfunction

    // expected result, written from the requirement text
    function automatic void model(input logic [63:0] p, input logic ks, input logic kp,
                                  input logic snx, input logic pr, input logic [63:0] a,
                                  input logic [63:0] ia, input logic ken, input logic [1:0] acc,
                                  output logic [2:0] e_perm, output logic e_grant,
                                  output logic [3:0] e_cause);
        logic       k;
        logic [2:0] code, ppp, nxp, kyp, need;
        logic [4:0] pk;
        int         sh;
        k    = pr ? kp : ks;
        code = {p[63], p[1:0]};
        if (!k) ppp = (code <= 3'd2) ? 3'b111 : (code == 3'd3 || code == 3'd6) ? 3'b101 : 3'b000;
        else    ppp = (code == 3'd2) ? 3'b111 : (code == 3'd1 || code == 3'd3) ? 3'b101 : 3'b000;
        nxp  = (p[2] || p[3] || snx) ? 3'b011 : 3'b111;
        pk   = {p[61:60], p[11:9]};
        sh   = 2 * (31 - int'(pk));
        kyp  = 3'b111;
        if (ken) begin
            if (a[sh + 1]) kyp[1] = 1'b0;
            if (a[sh])     kyp[0] = 1'b0;
            if (ia[sh])    kyp[2] = 1'b0;
        end
        need    = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b100 : 3'b001;
        e_perm  = nxp & ppp & kyp;
        e_grant = (need & e_perm) != 0;
        e_cause = 4'b0000;
        if (!e_grant) begin
            if (acc == 2'd2) begin
                if (!nxp[2])      e_cause[0] = 1'b1;
                else if (!ppp[2]) e_cause[1] = 1'b1;
                if (!kyp[2])      e_cause[2] = 1'b1;
            end else begin
                if ((need & ~ppp) != 0) e_cause[1] = 1'b1;
                if ((need & ~kyp) != 0) e_cause[2] = 1'b1;
                if (acc == 2'd1)        e_cause[3] = 1'b1;
            end
        end
    endfunction

    task automatic set_in(input logic [63:0] p, input logic ks, input logic kp, input logic snx,
                          input logic pr, input logic [63:0] a, input logic [63:0] ia,
                          input logic ken, input logic [1:0] acc);
        pte_word = p; seg_ks = ks; seg_kp = kp; seg_nx = snx; prob_state = pr;
        amr = a; iamr = ia; key_en = ken; acc_type = acc; in_valid = 1'b1;
    endtask

    // strobe one evaluation at a falling edge, sample one cycle later
    task automatic run(input string tag, input logic [63:0] p, input logic ks, input logic kp,
                       input logic snx, input logic pr, input logic [63:0] a,
                       input logic [63:0] ia, input logic ken, input logic [1:0] acc);
        logic [2:0] ep; logic eg; logic [3:0] ec;
        model(p, ks, kp, snx, pr, a, ia, ken, acc, ep, eg, ec);
        set_in(p, ks, kp, snx, pr, a, ia, ken, acc);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, 64'(out_valid), 64'd1);
        check({tag, " perm"},  64'(out_perm),  64'(ep));
        check({tag, " grant"}, 64'(out_grant), 64'(eg));
        check({tag, " cause"}, 64'(out_cause), 64'(ec));
    endtask

    task automatic t_reset;
        check("R12 reset valid", 64'(out_valid), 64'd0);
        check("R12 reset perm",  64'(out_perm),  64'd0);
        check("R12 reset grant", 64'(out_grant), 64'd0);
        check("R12 reset cause", 64'(out_cause), 64'd0);
    endtask

    task automatic t_code_tables;
        for (int key = 0; key < 2; key++) begin
            for (int pr = 0; pr < 2; pr++) begin
                for (int c = 0; c < 8; c++) begin
                    logic ks, kp;
                    ks = pr[0] ? ~key[0] : key[0];
                    kp = pr[0] ? key[0] : ~key[0];
                    run(key == 0 ? "R3 R1 key0 table" : "R4 R1 key1 table",
                        mk_pte(3'(c), 1'b0, 1'b0, 5'd7), ks, kp, 1'b0, pr[0],
                        64'd0, 64'd0, 1'b0, 2'd0);
                end
            end
        end
        // R2: bit 63 changes code 2 (rwx) into code 6 (rx) under key 0
        run("R2 code2", mk_pte(3'd2, 1'b0, 1'b0, 5'd0), 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 2'd1);
        check("R2 code2 store granted", 64'(out_grant), 64'd1);
        run("R2 code6", mk_pte(3'd6, 1'b0, 1'b0, 5'd0), 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 2'd1);
        check("R2 code6 store denied", 64'(out_grant), 64'd0);
    endtask

    task automatic t_noexec;
        run("R5 N fetch",   mk_pte(3'd0, 1'b1, 1'b0, 5'd3), 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 2'd2);
        check("R5 N perm", 64'(out_perm), 64'h3);
        run("R5 G fetch",   mk_pte(3'd0, 1'b0, 1'b1, 5'd3), 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 2'd2);
        run("R5 seg fetch", mk_pte(3'd0, 1'b0, 1'b0, 5'd3), 1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 2'd2);
        check("R5 seg cause", 64'(out_cause), 64'h1);
        run("R5 G store",   mk_pte(3'd0, 1'b0, 1'b1, 5'd3), 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b0, 2'd1);
        check("R5 G store granted", 64'(out_grant), 64'd1);
    endtask

    task automatic t_amr;
        logic [4:0] keys [3] = '{5'd0, 5'd31, 5'd17};
        foreach (keys[i]) begin
            run("R6 amr write bit store", mk_pte(3'd0, 0, 0, keys[i]), 0, 0, 0, 0,
                fld(keys[i], 2'b10), 0, 1'b1, 2'd1);
            check("R6 store denied", 64'(out_cause), 64'hC);
            run("R6 amr write bit load", mk_pte(3'd0, 0, 0, keys[i]), 0, 0, 0, 0,
                fld(keys[i], 2'b10), 0, 1'b1, 2'd0);
            run("R6 amr read bit load", mk_pte(3'd0, 0, 0, keys[i]), 0, 0, 0, 0,
                fld(keys[i], 2'b01), 0, 1'b1, 2'd0);
            check("R6 load denied", 64'(out_cause), 64'h4);
        end
        // neighbouring key field must not act
        run("R6 other key", mk_pte(3'd0, 0, 0, 5'd5), 0, 0, 0, 0, ~fld(5'd5, 2'b11), 0, 1'b1, 2'd1);
        check("R6 other key granted", 64'(out_grant), 64'd1);
        run("R6 disabled", mk_pte(3'd0, 0, 0, 5'd9), 0, 0, 0, 0, '1, '1, 1'b0, 2'd1);
        check("R6 disabled granted", 64'(out_perm), 64'h7);
    endtask

    task automatic t_iamr;
        run("R7 iamr fetch", mk_pte(3'd0, 0, 0, 5'd12), 0, 0, 0, 0, 0, fld(5'd12, 2'b01), 1'b1, 2'd2);
        check("R7 key cause", 64'(out_cause), 64'h4);
        run("R7 iamr high bit", mk_pte(3'd0, 0, 0, 5'd12), 0, 0, 0, 0, 0, fld(5'd12, 2'b10), 1'b1, 2'd2);
        check("R7 high bit ignored", 64'(out_grant), 64'd1);
        run("R7 iamr disabled", mk_pte(3'd0, 0, 0, 5'd12), 0, 0, 0, 0, 0, '1, 1'b0, 2'd2);
    endtask

    task automatic t_fetch_priority;
        run("R9 nx over pp", mk_pte(3'd6, 1'b1, 0, 5'd1), 1'b1, 0, 0, 0, 0, 0, 1'b0, 2'd2);
        check("R9 nx only", 64'(out_cause), 64'h1);
        run("R9 pp only", mk_pte(3'd6, 0, 0, 5'd1), 1'b1, 0, 0, 0, 0, 0, 1'b0, 2'd2);
        check("R9 pp cause", 64'(out_cause), 64'h2);
        run("R9 nx and key", mk_pte(3'd0, 1'b1, 0, 5'd1), 0, 0, 0, 0, 0, fld(5'd1, 2'b01), 1'b1, 2'd2);
        check("R9 nx plus key", 64'(out_cause), 64'h5);
    endtask

    task automatic t_data_cause;
        run("R10 store on rx", mk_pte(3'd3, 0, 0, 5'd2), 0, 0, 0, 0, 0, 0, 1'b0, 2'd1);
        check("R10 pp store", 64'(out_cause), 64'hA);
        run("R10 store pp and amr", mk_pte(3'd3, 0, 0, 5'd2), 0, 0, 0, 0, fld(5'd2, 2'b11), 0, 1'b1, 2'd1);
        check("R10 all", 64'(out_cause), 64'hE);
        run("R10 load none", mk_pte(3'd0, 0, 0, 5'd2), 1'b1, 0, 0, 0, 0, 0, 1'b0, 2'd0);
        check("R10 load pp", 64'(out_cause), 64'h2);
        run("R8 code3 as load", mk_pte(3'd3, 0, 0, 5'd2), 0, 0, 0, 0, 0, 0, 1'b0, 2'd3);
        check("R8 code3 granted", 64'(out_grant), 64'd1);
        run("R8 code3 read masked", mk_pte(3'd0, 0, 0, 5'd2), 0, 0, 0, 0, fld(5'd2, 2'b01), 0, 1'b1, 2'd3);
    endtask

    task automatic t_timing;
        logic [2:0] ep; logic eg; logic [3:0] ec;
        set_in(mk_pte(3'd2, 0, 0, 5'd4), 0, 0, 0, 0, 0, 0, 1'b0, 2'd1);
        @(posedge clk); @(negedge clk);
        check("R11 first valid", 64'(out_valid), 64'd1);
        check("R11 first grant", 64'(out_grant), 64'd1);
        model(mk_pte(3'd4, 0, 0, 5'd4), 0, 0, 0, 0, 0, 0, 1'b0, 2'd1, ep, eg, ec);
        set_in(mk_pte(3'd4, 0, 0, 5'd4), 0, 0, 0, 0, 0, 0, 1'b0, 2'd1);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        check("R11 b2b valid", 64'(out_valid), 64'd1);
        check("R11 b2b cause", 64'(out_cause), 64'(ec));
        pte_word = mk_pte(3'd0, 0, 0, 5'd4); acc_type = 2'd0;
        @(posedge clk); @(negedge clk);
        check("R11 idle valid", 64'(out_valid), 64'd0);
        check("R11 idle hold grant", 64'(out_grant), 64'(eg));
        check("R11 idle hold cause", 64'(out_cause), 64'(ec));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; acc_type = 2'd0; pte_word = '0;
        seg_ks = 0; seg_kp = 0; seg_nx = 0; prob_state = 0; amr = '0; iamr = '0; key_en = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_code_tables();
        t_noexec();
        t_amr();
        t_iamr();
        t_fetch_priority();
        t_data_cause();
        t_timing();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule